// File: doc/BRIEF.md
# Bidirectional TFT Gate Scan Sequencer

This block produces the row-select pattern for a 240-row thin-film-transistor panel gate driver. A token launched by an active-low start pulse walks through the rows, moving one row on each rising edge of the vertical shift clock. A direction input sets whether the walk runs from the lowest output to the highest or the other way. The selected rows are driven high and all other rows are driven low.

Two mode bits choose how the token becomes row pulses. Each row can be driven for one clock period. It can be driven for two adjacent periods, which makes neighbouring rows overlap. It can be driven for two periods with one idle period between them. A fourth setting holds every row low. Outputs are logic level only; level shifting is done elsewhere.

Two sequencers can share one panel without a carry wire between them. The chip that comes second in the chain counts shift clocks from the common start pulse and launches its own token once the first chip has covered its rows. Which position a chip takes depends on its chain-position input and its direction input together.

Top module: `gate_scan_seq`

## Requirements
- R1: While `rst_ni` is low, every bit of `rows_o` is 0 and any pending launch is cancelled. The first start event after reset behaves as on a fresh chip.
- R2: A start event is a rising clock edge at which `start_n_i` is sampled 0 and was sampled 1 at the previous edge, or was held in reset. Holding `start_n_i` low across several edges gives exactly one scan.
- R3: A chip is first in the chain when `chain_sel_i` equals `dir_fwd_i`. For a first chip with the start event at edge E, scan position 0 is selected after edge E.
- R4: When `dir_fwd_i` is 1, scan position k drives `rows_o[k]`. When it is 0, scan position k drives `rows_o[ROWS-1-k]`. Direction is sampled at every edge.
- R5: With mode {`mode_a_i`,`mode_b_i`} = 11 (single pulse), scan position k is high only in the period after edge E+k.
- R6: With mode 01 (adjacent double pulse), scan position k is high after edges E+k and E+k+1, so neighbouring rows overlap by one period.
- R7: With mode 10 (split double pulse), scan position k is high after edges E+k and E+k+2 and low after edge E+k+1.
- R8: With mode 00, `rows_o` is all 0 after the edge, while the token keeps moving. Returning to another mode mid-scan shows the token at its proper position.
- R9: A chip that is second in the chain launches its token ROWS edges after the start event. Scan position 0 is selected after edge E+ROWS. The position is fixed at the start event.
- R10: Mode bits are sampled on the rising edge, and `rows_o` changes only after rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Vertical shift clock; everything updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_n_i | input | 1 | Active-low frame start pulse |
| dir_fwd_i | input | 1 | 1: scan from low to high outputs; 0: reverse |
| chain_sel_i | input | 1 | Chain-position select, combined with direction |
| mode_a_i | input | 1 | First scan-mode bit |
| mode_b_i | input | 1 | Second scan-mode bit |
| rows_o | output | ROWS | Row select vector, 1 = row selected |

## Verification
On every cycle, the assertions check four things: the forced-off setting clears every row, a start event on a leading chip lights the first row in scan order, the token chain advances exactly one place per edge, and the launch counter stays within range. The exact pulse timing of the two double-pulse modes, the offset of a trailing chip, the direction mapping of every row, and the single-scan result of a long start pulse show up only in the bench scenarios. There, each output vector is compared with a model that tracks edges since the start event.

// File: rtl/gate_scan_pkg.sv
package gate_scan_pkg;

    // mode encoding is {mode_a, mode_b}
    typedef enum logic [1:0] {
        SCAN_OFF  = 2'b00,
        SCAN_ADJ  = 2'b01,
        SCAN_SPLT = 2'b10,
        SCAN_ONE  = 2'b11
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e mode;
        logic       fwd;
    } scan_cfg_t;

endpackage

// File: rtl/gsq_launch.sv
module gsq_launch #(
    parameter int ROWS = 240
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_n_i,
    input  logic chain_sel_i,
    input  logic dir_fwd_i,
    output logic inject_o
);
    localparam int CW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

    typedef struct packed {
        logic          prev_n;
        logic          armed;
        logic [CW-1:0] cnt;
    } launch_st_t;

    launch_st_t st_d, st_q;
    logic start_evt, lead, fire_late;

    always_comb begin
        st_d      = st_q;
        start_evt = !start_n_i && st_q.prev_n;
        lead      = (chain_sel_i == dir_fwd_i);
        fire_late = st_q.armed && (st_q.cnt == LAST);
        st_d.prev_n = start_n_i;
        if (st_q.armed) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (fire_late) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end
        if (start_evt && !lead) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end
        inject_o = (start_evt && lead) || fire_late;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{prev_n: 1'b1, armed: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.armed |-> (st_q.cnt <= LAST));

endmodule

// File: rtl/gsq_chain.sv
module gsq_chain #(
    parameter int LEN = 242
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           inject_i,
    output logic [LEN-1:0] tok_o
);
    logic [LEN-1:0] tok_d, tok_q;

    always_comb begin
        tok_d = {tok_q[LEN-2:0], inject_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tok_q <= '0;
        end else begin
            tok_q <= tok_d;
        end
    end

    assign tok_o = tok_q;

    // R5
    token_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (tok_q[LEN-1:1] == $past(tok_q[LEN-2:0])));

endmodule

// File: rtl/gsq_rowmap.sv
module gsq_rowmap
    import gate_scan_pkg::*;
#(
    parameter int ROWS = 240,
    localparam int LEN = ROWS + 2
) (
    input  logic [LEN-1:0]  tok_i,
    input  scan_cfg_t       cfg_i,
    output logic [ROWS-1:0] rows_o
);
    logic [ROWS-1:0] scan_pos;

    for (genvar k = 0; k < ROWS; k++) begin : g_pos
        always_comb begin
            unique case (cfg_i.mode)
                SCAN_ONE:  scan_pos[k] = tok_i[k];
                SCAN_ADJ:  scan_pos[k] = tok_i[k] | tok_i[k+1];
                SCAN_SPLT: scan_pos[k] = tok_i[k] | tok_i[k+2];
                default:   scan_pos[k] = 1'b0;
            endcase
        end
    end

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign rows_o[i] = cfg_i.fwd ? scan_pos[i] : scan_pos[ROWS-1-i];
    end

endmodule

// File: rtl/gate_scan_seq.sv
module gate_scan_seq
    import gate_scan_pkg::*;
#(
    parameter int ROWS = 240
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_n_i,
    input  logic            dir_fwd_i,
    input  logic            chain_sel_i,
    input  logic            mode_a_i,
    input  logic            mode_b_i,
    output logic [ROWS-1:0] rows_o
);
    localparam int LEN = ROWS + 2;

    scan_cfg_t      cfg_d, cfg_q;
    logic           inject;
    logic [LEN-1:0] tok;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.mode = scan_mode_e'({mode_a_i, mode_b_i});
        cfg_d.fwd  = dir_fwd_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{mode: SCAN_OFF, fwd: 1'b1};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    gsq_launch #(.ROWS(ROWS)) u_launch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_n_i   (start_n_i),
        .chain_sel_i (chain_sel_i),
        .dir_fwd_i   (dir_fwd_i),
        .inject_o    (inject)
    );

    gsq_chain #(.LEN(LEN)) u_chain (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .inject_i (inject),
        .tok_o    (tok)
    );

    gsq_rowmap #(.ROWS(ROWS)) u_map (
        .tok_i  (tok),
        .cfg_i  (cfg_q),
        .rows_o (rows_o)
    );

    // R8
    forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_a_i && !mode_b_i) |=> (rows_o == '0));

    // R3
    lead_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_n_i && $past(start_n_i) && (chain_sel_i == dir_fwd_i)
         && mode_a_i && mode_b_i)
        |=> ($past(dir_fwd_i) ? rows_o[0] : rows_o[ROWS-1]));

endmodule

// File: tb/gate_scan_seq_test.sv
module gate_scan_seq_test;
    localparam int ROWS = 240;
    localparam int CLK_PERIOD = 10;
    localparam int NONE = 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1, dir_fwd = 1'b1, chain_sel = 1'b1, mode_a = 1'b0, mode_b = 1'b0;
    logic [ROWS-1:0] rows;

    int n_cmp = 0, n_bad = 0;
    string req = "R1";
    bit done = 1'b0;

    int  m_since = NONE;
    bit  m_prev = 1'b1, m_first = 1'b1, m_fwd = 1'b1;
    logic [1:0] m_mode = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_scan_seq #(.ROWS(ROWS)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_n_i(start_n), .dir_fwd_i(dir_fwd),
        .chain_sel_i(chain_sel), .mode_a_i(mode_a), .mode_b_i(mode_b), .rows_o(rows)
    );

    function automatic logic [ROWS-1:0] expect_rows();
        logic [ROWS-1:0] v = '0;
        int j;
        if (m_since >= NONE) return v;
        j = m_first ? m_since : m_since - ROWS;
        for (int i = 0; i < ROWS; i++) begin
            int k = m_fwd ? i : ROWS-1-i;
            case (m_mode)
                2'b11: v[i] = (j == k);
                2'b01: v[i] = (j == k) || (j == k+1);
                2'b10: v[i] = (j == k) || (j == k+2);
                default: v[i] = 1'b0;
            endcase
        end
        return v;
    endfunction

    task automatic model_edge();
        if (!start_n && m_prev) begin
            m_since = 0;
            m_first = (chain_sel == dir_fwd);
        end else if (m_since < NONE) begin
            m_since++;
        end
        m_prev = start_n;
        m_mode = {mode_a, mode_b};
        m_fwd  = dir_fwd;
    endtask

    task automatic check_now();
        logic [ROWS-1:0] e = expect_rows();
        n_cmp++;
        if (rows !== e) begin
            n_bad++;
            $display("FAIL %s: rows=%h expected=%h", req, rows, e);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        check_now();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_n = 1'b1;
        m_since = NONE; m_prev = 1'b1; m_mode = 2'b00; m_fwd = 1'b1;
        #1;
        req = "R1";
        check_now();
        repeat (2) @(negedge clk);
        check_now();
        rst_n = 1'b1;
    endtask

    task automatic frame(input logic [1:0] md, input bit fwd, input bit cs,
                         input int hold, input int len);
        mode_a = md[1]; mode_b = md[0]; dir_fwd = fwd; chain_sel = cs;
        start_n = 1'b0;
        for (int c = 0; c < hold; c++) tick();
        start_n = 1'b1;
        for (int c = hold; c < len; c++) tick();
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // R8 flush with rows forced off
        req = "R8";
        frame(2'b00, 1'b1, 1'b1, 3, ROWS + 10);
        // R3 / R5 leading chip, forward, single pulse
        req = "R3_R5";
        frame(2'b11, 1'b1, 1'b1, 1, 2*ROWS + 4);
        // R4 reverse direction, leading (both low)
        req = "R4";
        frame(2'b11, 1'b0, 1'b0, 1, 2*ROWS + 4);
        // R6 adjacent double pulse
        req = "R6";
        frame(2'b01, 1'b1, 1'b1, 1, 2*ROWS + 4);
        // R7 split double pulse, reverse
        req = "R7";
        frame(2'b10, 1'b0, 1'b0, 1, 2*ROWS + 4);
        // R9 trailing chip, both combinations
        req = "R9";
        frame(2'b11, 1'b1, 1'b0, 1, 2*ROWS + 4);
        frame(2'b01, 1'b0, 1'b1, 1, 2*ROWS + 4);
        // R2 long start pulse gives one scan
        req = "R2";
        frame(2'b11, 1'b1, 1'b1, 7, 2*ROWS + 4);
        // R8 off mid-scan, then back on
        req = "R8";
        mode_a = 1'b1; mode_b = 1'b1; start_n = 1'b0; tick(); start_n = 1'b1;
        for (int c = 0; c < 60; c++) tick();
        mode_a = 1'b0; mode_b = 1'b0;
        for (int c = 0; c < 40; c++) tick();
        mode_a = 1'b1; mode_b = 1'b1;
        for (int c = 0; c < 2*ROWS; c++) tick();
        // R1 reset in mid-scan cancels everything
        req = "R1";
        chain_sel = 1'b0; dir_fwd = 1'b1;
        start_n = 1'b0; tick(); start_n = 1'b1;
        for (int c = 0; c < 30; c++) tick();
        do_reset();
        for (int c = 0; c < 2*ROWS; c++) tick();
        // R10 random modes and directions changed between edges
        req = "R10";
        for (int f = 0; f < 12; f++) begin
            logic [1:0] md = 2'($urandom_range(3));
            mode_a = md[1]; mode_b = md[0];
            dir_fwd = 1'($urandom_range(1));
            chain_sel = 1'($urandom_range(1));
            start_n = 1'b0;
            for (int c = 0; c < int'($urandom_range(1, 4)); c++) tick();
            start_n = 1'b1;
            for (int c = 0; c < 2*ROWS + 4; c++) begin
                if ($urandom_range(15) == 0) begin
                    md = 2'($urandom_range(3));
                    mode_a = md[1]; mode_b = md[0];
                end
                if ($urandom_range(63) == 0) dir_fwd = ~dir_fwd;
                tick();
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule